// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Encoder

This block decides which interrupt source of a 16550-style serial port is reported to the host, and with which identification code. It holds the interrupt enable bits, the transmit-empty pending flag, the sticky overrun and break flags, and the FIFO mode and trigger selection. From these and from the receiver, transmitter and modem-line status inputs it produces a registered identification byte and a registered interrupt request.

The FIFOs, the shift registers and the baud-rate logic sit outside the block. They appear here only as level inputs (data ready, receive count, timeout pending, holding register empty, parity and framing error of the head character, modem deltas) and as single-cycle strobes (holding register written, holding register drained, overrun, break). The host register decoder forwards its write strobes for the enable and FIFO control registers. It also forwards its read strobes for the identification and line status registers, so that the side effects of those reads take place here.

Every result is registered. A change on any input or strobe appears on `iir_q` and `irq` at the next rising clock edge.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst_n` is low, `iir_q` is 0x01, `irq` is 0, `ier_q` is 0 and both sticky flags are 0. The pending transmit-empty flag is clear, and FIFO mode is off with trigger select 0.
- R2: A cycle with `ier_we` high stores `ier_wdata[3:0]` in `ier_q` and drops bits 7:4. Bit 0 enables receive data and timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R3: Code 0x6 (line status) is reported when enable bit 2 is set and any of these is true: sticky overrun, sticky break, `rx_parity_err` or `rx_frame_err`. This code outranks all others.
- R4: Code 0xC (character timeout) is reported when enable bit 0 is set and `rx_timeout` is high, unless a line status condition is active. There is no separate enable for it.
- R5: Code 0x4 (receive data) is reported when enable bit 0 is set and `rx_ready` is high. In FIFO mode, `rx_count` must also be at least the trigger level selected by `fcr_wdata[7:6]`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. FIFO mode is taken from `fcr_wdata[0]`. This code ranks below timeout.
- R6: Code 0x2 (transmit empty) is reported when enable bit 1 is set and the pending flag is set, unless a higher source is active. `thr_write` clears the flag. Otherwise `thr_drained` sets it.
- R7: Code 0x0 (modem status) is reported when enable bit 3 is set and any bit of `msr_delta` is high, unless a higher source is active. With no active source the code is 0x1.
- R8: An `iir_re` strobe while `iir_q[3:0]` shows 0x2 clears the pending flag, unless `thr_drained` or an enable change sets it in the same cycle.
- R9: When an `ier_we` write changes enable bit 1, the pending flag becomes the new bit ANDed with `thr_empty`. This takes precedence over every other event in that cycle.
- R10: `iir_q[7:6]` read 11 while FIFO mode is on and 00 otherwise. `iir_q[5:4]` are always 0.
- R11: `ovr_set` and `brk_set` set bits 0 and 1 of `lsr_flags_q`. An `lsr_re` strobe clears both, but a set strobe in the same cycle wins. Parity and framing errors are inputs and are never stored.
- R12: `irq` is high exactly when the registered code is not 0x1. Both are updated at the clock edge that follows the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_we | input | 1 | Interrupt enable register write strobe |
| ier_wdata | input | 8 | Write data for the enable register |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control data: bit 0 FIFO mode, bits 7:6 trigger select |
| iir_re | input | 1 | Identification register read strobe |
| lsr_re | input | 1 | Line status register read strobe |
| thr_write | input | 1 | Holding register written by the host |
| thr_drained | input | 1 | Holding register or transmit FIFO became empty |
| thr_empty | input | 1 | Holding register empty level |
| ovr_set | input | 1 | Receive overrun event |
| brk_set | input | 1 | Break received event |
| rx_parity_err | input | 1 | Parity error of the character at the receive head |
| rx_frame_err | input | 1 | Framing error of the character at the receive head |
| rx_ready | input | 1 | Receive data ready level |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_timeout | input | 1 | Character timeout pending level |
| msr_delta | input | 4 | Modem status change bits |
| ier_q | output | 4 | Stored interrupt enable bits |
| lsr_flags_q | output | 2 | Sticky flags: bit 0 overrun, bit 1 break |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions rely on the environment to keep `rx_count` within 0 to DEPTH. They also assume that each strobe lasts a single cycle, as the host decoder and transmitter give it. The stimulus meets both conditions: counts are drawn only from that range, and every strobe is raised for one clock and then dropped. Strobes that conflict in the same cycle are applied on purpose. This shows that the set-over-clear precedence and the enable-change precedence hold, so the properties remain valid when several events arrive together.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned IER_BITS = 4;

  // enable bit positions (decoded by host software, kept fixed)
  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_THRE  = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;

  // sticky flag positions
  localparam int unsigned FL_OVR = 0;
  localparam int unsigned FL_BRK = 1;
  localparam int unsigned FL_N   = 2;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  function automatic int unsigned trig_level(input int unsigned sel);
    case (sel)
      0:       trig_level = 1;
      1:       trig_level = 4;
      2:       trig_level = 8;
      default: trig_level = 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_enables.sv
module uart_irq_enables
  import uart_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ier_we,
  input  logic [IER_BITS-1:0] ier_wdata,
  input  logic                thr_write,
  input  logic                thr_drained,
  input  logic                thr_empty,
  input  logic                iir_re,
  input  logic                iir_shows_thre,
  output logic [IER_BITS-1:0] ier_d,
  output logic                pend_d,
  output logic [IER_BITS-1:0] ier_q,
  output logic                pend_q
);

  logic thre_toggle;
  logic ier_en;
  logic pend_en;

  assign thre_toggle = ier_we && (ier_wdata[EN_THRE] != ier_q[EN_THRE]);
  assign ier_en      = ier_we;

  always_comb begin
    ier_d = ier_en ? ier_wdata : ier_q;
  end

  always_comb begin
    pend_d = pend_q;
    if (thre_toggle)                  pend_d = ier_wdata[EN_THRE] & thr_empty;
    else if (thr_write)               pend_d = 1'b0;
    else if (thr_drained)             pend_d = 1'b1;
    else if (iir_re && iir_shows_thre) pend_d = 1'b0;
  end

  assign pend_en = (pend_d != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
    end else if (ier_en) begin
      ier_q <= ier_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] flag_d,
  output logic [N-1:0] flag_q
);

  for (genvar g = 0; g < N; g++) begin : g_sticky
    logic en;
    always_comb begin
      flag_d[g] = set_vec[g] | (flag_q[g] & ~clr);
    end
    assign en = set_vec[g] | clr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else if (en) begin
        flag_q[g] <= flag_d[g];
      end
    end
  end

endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic [IER_BITS-1:0] ier,
  input  logic                pend,
  input  logic [FL_N-1:0]     flags,
  input  logic                rx_parity_err,
  input  logic                rx_frame_err,
  input  logic                rx_ready,
  input  logic [CNT_W-1:0]    rx_count,
  input  logic                rx_timeout,
  input  logic                fifo_en,
  input  logic [1:0]          trig_sel,
  input  logic [3:0]          msr_delta,
  output irq_id_e             code
);

  logic [CNT_W-1:0] lvl [4];

  for (genvar g = 0; g < 4; g++) begin : g_lvl
    assign lvl[g] = CNT_W'(trig_level(g));
  end

  logic src_line, src_tmo, src_rx, src_thre, src_modem, at_level;

  assign at_level  = (rx_count >= lvl[trig_sel]);
  assign src_line  = ier[EN_LINE] & ((|flags) | rx_parity_err | rx_frame_err);
  assign src_tmo   = ier[EN_RX] & rx_timeout;
  assign src_rx    = ier[EN_RX] & rx_ready & (~fifo_en | at_level);
  assign src_thre  = ier[EN_THRE] & pend;
  assign src_modem = ier[EN_MODEM] & (|msr_delta);

  always_comb begin
    if (src_line)       code = ID_LINE;
    else if (src_tmo)   code = ID_TIMEOUT;
    else if (src_rx)    code = ID_RXDATA;
    else if (src_thre)  code = ID_THRE;
    else if (src_modem) code = ID_MODEM;
    else                code = ID_NONE;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_we,
  input  logic [7:0]       ier_wdata,
  input  logic             fcr_we,
  input  logic [7:0]       fcr_wdata,
  input  logic             iir_re,
  input  logic             lsr_re,
  input  logic             thr_write,
  input  logic             thr_drained,
  input  logic             thr_empty,
  input  logic             ovr_set,
  input  logic             brk_set,
  input  logic             rx_parity_err,
  input  logic             rx_frame_err,
  input  logic             rx_ready,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_timeout,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       ier_q,
  output logic [1:0]       lsr_flags_q,
  output logic [7:0]       iir_q,
  output logic             irq
);

  logic [IER_BITS-1:0] ier_d;
  logic                pend_d, pend_q;
  logic [FL_N-1:0]     flag_d, flag_q, flag_set;
  logic                fen_d, fen_q;
  logic [1:0]          trig_d, trig_q;
  irq_id_e             code;
  logic [7:0]          iir_d;
  logic                irq_d;
  logic                iir_shows_thre;

  assign iir_shows_thre = (iir_q[3:0] == ID_THRE);

  uart_irq_enables u_en (
    .clk            (clk),
    .rst_n          (rst_n),
    .ier_we         (ier_we),
    .ier_wdata      (ier_wdata[IER_BITS-1:0]),
    .thr_write      (thr_write),
    .thr_drained    (thr_drained),
    .thr_empty      (thr_empty),
    .iir_re         (iir_re),
    .iir_shows_thre (iir_shows_thre),
    .ier_d          (ier_d),
    .pend_d         (pend_d),
    .ier_q          (ier_q),
    .pend_q         (pend_q)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[FL_OVR] = ovr_set;
    flag_set[FL_BRK] = brk_set;
  end

  uart_irq_status #(.N(FL_N)) u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (flag_set),
    .clr     (lsr_re),
    .flag_d  (flag_d),
    .flag_q  (flag_q)
  );

  assign lsr_flags_q = flag_q;

  // FIFO mode and trigger selection
  always_comb begin
    fen_d  = fcr_we ? fcr_wdata[0]   : fen_q;
    trig_d = fcr_we ? fcr_wdata[7:6] : trig_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q  <= 1'b0;
      trig_q <= 2'b00;
    end else if (fcr_we) begin
      fen_q  <= fen_d;
      trig_q <= trig_d;
    end
  end

  // encoder sees next-state values so every event lands in one clock
  uart_irq_encode #(.CNT_W(CNT_W)) u_enc (
    .ier           (ier_d),
    .pend          (pend_d),
    .flags         (flag_d),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err),
    .rx_ready      (rx_ready),
    .rx_count      (rx_count),
    .rx_timeout    (rx_timeout),
    .fifo_en       (fen_d),
    .trig_sel      (trig_d),
    .msr_delta     (msr_delta),
    .code          (code)
  );

  always_comb begin
    iir_d = {fen_d, fen_d, 2'b00, code};
    irq_d = (code != ID_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= {4'h0, ID_NONE};
      irq   <= 1'b0;
    end else begin
      iir_q <= iir_d;
      irq   <= irq_d;
    end
  end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ier_we,
  input logic [7:0]       ier_wdata,
  input logic             fcr_we,
  input logic [7:0]       fcr_wdata,
  input logic             iir_re,
  input logic             lsr_re,
  input logic             thr_drained,
  input logic             ovr_set,
  input logic [3:0]       ier_q,
  input logic [1:0]       lsr_flags_q,
  input logic [7:0]       iir_q,
  input logic             irq,
  input logic [CNT_W-1:0] rx_count
);

  // R2
  ier_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_we |=> ier_q == $past(ier_wdata[3:0]));

  // R3
  line_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_set && !ier_we && ier_q[2]) |=> iir_q[3:0] == 4'h6);

  // R7
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iir_q[3:0] inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h6, 4'hC});

  // R8
  thre_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_re && iir_q[3:0] == 4'h2 && !ier_we && !thr_drained) |=> iir_q[3:0] != 4'h2);

  // R10
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we |=> iir_q[7:4] == {{2{$past(fcr_wdata[0])}}, 2'b00});

  // R11
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_re && !ovr_set) |=> !lsr_flags_q[0]);

  // R12
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir_q[3:0] != 4'h1));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(16));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ier_we      (ier_we),
  .ier_wdata   (ier_wdata),
  .fcr_we      (fcr_we),
  .fcr_wdata   (fcr_wdata),
  .iir_re      (iir_re),
  .lsr_re      (lsr_re),
  .thr_drained (thr_drained),
  .ovr_set     (ovr_set),
  .ier_q       (ier_q),
  .lsr_flags_q (lsr_flags_q),
  .iir_q       (iir_q),
  .irq         (irq),
  .rx_count    (rx_count)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

  localparam int unsigned CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_we = 0, fcr_we = 0, iir_re = 0, lsr_re = 0;
  logic [7:0] ier_wdata = 0, fcr_wdata = 0;
  logic thr_write = 0, thr_drained = 0, thr_empty = 0;
  logic ovr_set = 0, brk_set = 0, rx_parity_err = 0, rx_frame_err = 0;
  logic rx_ready = 0, rx_timeout = 0;
  logic [CNT_W-1:0] rx_count = 0;
  logic [3:0] msr_delta = 0;
  logic [3:0] ier_q;
  logic [1:0] lsr_flags_q;
  logic [7:0] iir_q;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model of the state
  logic [3:0] m_ier;
  logic       m_pend, m_ovr, m_brk, m_fen;
  logic [1:0] m_trig;
  logic [7:0] m_iir;

  always #2 clk = ~clk;

  uart_irq_ident u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  function automatic logic [3:0] exp_code();
    if (m_ier[2] && (m_ovr || m_brk || rx_parity_err || rx_frame_err)) return 4'h6;
    if (m_ier[0] && rx_timeout) return 4'hC;
    if (m_ier[0] && rx_ready && (!m_fen || int'(rx_count) >= lvl(m_trig))) return 4'h4;
    if (m_ier[1] && m_pend) return 4'h2;
    if (m_ier[3] && (msr_delta != 0)) return 4'h0;
    return 4'h1;
  endfunction

  task automatic model_step();
    logic [3:0] c;
    if (ier_we && (ier_wdata[1] != m_ier[1])) m_pend = ier_wdata[1] & thr_empty; // R9
    else if (thr_write)   m_pend = 0;
    else if (thr_drained) m_pend = 1;
    else if (iir_re && m_iir[3:0] == 4'h2) m_pend = 0;                          // R8
    if (ier_we) m_ier = ier_wdata[3:0];
    m_ovr = ovr_set | (m_ovr & ~lsr_re);
    m_brk = brk_set | (m_brk & ~lsr_re);
    if (fcr_we) begin m_fen = fcr_wdata[0]; m_trig = fcr_wdata[7:6]; end
    c = exp_code();
    m_iir = {m_fen, m_fen, 2'b00, c};
  endtask

  function automatic string code_tag(input logic [3:0] c);
    case (c)
      4'h6: return "R3";
      4'hC: return "R4";
      4'h4: return "R5";
      4'h2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // entered at a falling edge with inputs already driven
  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    chk(code_tag(m_iir[3:0]), iir_q[3:0], m_iir[3:0]);
    chk("R10", iir_q[7:4], m_iir[7:4]);
    chk("R12", irq, m_iir[3:0] != 4'h1);
    chk("R2", ier_q, m_ier);
    chk("R11", lsr_flags_q, {m_brk, m_ovr});
    @(negedge clk);
    ier_we = 0; fcr_we = 0; iir_re = 0; lsr_re = 0;
    thr_write = 0; thr_drained = 0; ovr_set = 0; brk_set = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    m_ier = 0; m_pend = 0; m_ovr = 0; m_brk = 0; m_fen = 0; m_trig = 0; m_iir = 8'h01;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", iir_q, 8'h01);
    chk("R1", irq, 0);
    chk("R1", ier_q, 0);
    chk("R1", lsr_flags_q, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2: every write value keeps only the low nibble
    for (int v = 0; v < 256; v++) begin
      ier_we = 1; ier_wdata = 8'(v);
      tick();
    end
    ier_we = 1; ier_wdata = 0; tick();

    // R3..R7 priority sweep over all enables and status patterns
    for (int e = 0; e < 16; e++) begin
      for (int p = 0; p < 128; p++) begin
        ier_we = 1; ier_wdata = 8'(e | ((p & 1) << 4));
        thr_empty = p[1];
        rx_ready = p[2]; rx_timeout = p[3];
        rx_parity_err = p[4] & p[5]; rx_frame_err = p[4] & ~p[5];
        msr_delta = 4'(p[6] << (p & 3));
        ovr_set = (p % 37) == 5; brk_set = (p % 41) == 7;
        thr_drained = (p % 5) == 0;
        tick();
        lsr_re = p[0]; iir_re = p[1];
        tick();
      end
    end
    rx_parity_err = 0; rx_frame_err = 0; rx_timeout = 0; msr_delta = 0;
    lsr_re = 1; tick();

    // R5 / R10: trigger levels across all counts, FIFO on and off
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 4; s++) begin
        fcr_we = 1; fcr_wdata = 8'((s << 6) | f); ier_we = 1; ier_wdata = 8'h01;
        rx_ready = 1; rx_count = 0;
        tick();
        for (int n = 0; n <= 16; n++) begin
          rx_count = CNT_W'(n);
          tick();
          chk("R5", iir_q[3:0], (f == 0 || n >= lvl(2'(s))) ? 4'h4 : 4'h1);
        end
      end
    end
    rx_ready = 0; rx_count = 0;
    fcr_we = 1; fcr_wdata = 8'h00; tick();

    // R8: reading the ident while it shows transmit empty clears it
    ier_we = 1; ier_wdata = 8'h00; tick();
    thr_empty = 1; ier_we = 1; ier_wdata = 8'h02; tick();
    chk("R8", iir_q[3:0], 4'h2);
    iir_re = 1; tick();
    chk("R8", iir_q[3:0], 4'h1);
    tick();
    chk("R8", iir_q[3:0], 4'h1);

    // R9: enable change outranks a drain event in the same cycle
    ier_we = 1; ier_wdata = 8'h00; tick();
    thr_empty = 0; ier_we = 1; ier_wdata = 8'h02; thr_drained = 1; tick();
    chk("R9", iir_q[3:0], 4'h1);
    thr_drained = 1; tick();
    chk("R6", iir_q[3:0], 4'h2);
    thr_write = 1; thr_drained = 1; tick();
    chk("R6", iir_q[3:0], 4'h1);

    // R11: set beats clear in the same cycle; parity is not stored
    ier_we = 1; ier_wdata = 8'h04; ovr_set = 1; lsr_re = 1; tick();
    chk("R11", lsr_flags_q, 2'b01);
    lsr_re = 1; tick();
    chk("R11", lsr_flags_q, 2'b00);
    rx_parity_err = 1; tick();
    chk("R3", iir_q[3:0], 4'h6);
    rx_parity_err = 0; tick();
    chk("R11", iir_q[3:0], 4'h1);

    // random mixed traffic
    for (int i = 0; i < 6000; i++) begin
      automatic int r = int'($urandom);
      ier_we = (r & 7) == 0; ier_wdata = 8'($urandom);
      fcr_we = (r & 63) == 1; fcr_wdata = 8'($urandom);
      iir_re = r[3]; lsr_re = r[4] & r[5];
      thr_write = r[6] & r[7]; thr_drained = r[8] & r[9]; thr_empty = r[10];
      ovr_set = (r[13:11] == 0); brk_set = (r[16:14] == 0);
      rx_parity_err = (r[19:17] == 0); rx_frame_err = (r[22:20] == 0);
      rx_ready = r[23]; rx_timeout = r[24] & r[25];
      rx_count = CNT_W'($urandom_range(0, 16));
      msr_delta = 4'(r[29:26] & {4{r[30]}});
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule